// File: doc/BRIEF.md
# Two-Step Flash Converter Interface Sequencer

This block is the synchronous controller of an 8-bit converter that resolves its result in two 4-bit steps: an upper-nibble flash stage followed by a lower-nibble flash stage. It watches three active-low host strobes (chip select, write, read) and a static strap input. From these it drives the zero/compare phase of each comparator stage, pulses a latch enable as each nibble is captured, and enables the 8-bit result onto the data bus. It also drives an active-low completion interrupt and a busy flag. The comparator results reach it as ready-made 4-bit digital codes. All phase intervals are counted in clock cycles, derived from a clock-frequency parameter and nanosecond parameters.

With the strap low, the read strobe alone runs a conversion, and both phases are timed inside the block. With the strap high, a write pulse samples the input and the read strobe collects the result. A read may come early, which completes the conversion at once, or late, after the interrupt. With chip select and read tied low, a write pulse alone converts. All strobes pass through two-flop synchronizers, so every reaction happens two clock edges after the pin changes. Every output is registered.

Top module: `hfc_sequencer`

## Requirements
- R1: The strap `mode` selects the trigger. When `mode`=0, only a read assertion (`cs_n`=0 and `rd_n`=0) starts a conversion, and a write pulse leaves `busy` at 0. When `mode`=1, only a write assertion starts one, and a read pulse from idle leaves `busy` at 0.
- R2: In read-triggered mode, a synchronized falling edge of the read assertion sets `up_compare`=1, `lo_compare`=0 and `busy`=1. A stage in its zero phase shows 0 on its compare output.
- R3: In read-triggered mode, the upper stage compares for SPAN cycles (SPAN = ceil(PHASE_NS × CLK_MHZ / 1000), 200 by default). Then `up_res` is captured with a one-cycle `up_latch` pulse, and the lower stage compares for another SPAN cycles. Then `lo_res` is captured, `int_n` falls, `busy` falls, and `data_out` = {upper nibble in bits 7:4, lower nibble in bits 3:0} with `data_oe`=1.
- R4: In read-triggered mode, dropping the read assertion before completion returns the block to idle: both stages go to zero, `busy`=0, and `int_n` stays 1.
- R5: In write-then-read mode, a write assertion sets `up_compare`=1 and `lo_compare`=0. Releasing the write captures `up_res` with an `up_latch` pulse and switches the stage phases to `up_compare`=0 and `lo_compare`=1.
- R6: In write-then-read mode with no read, `int_n` falls and `busy` clears SPAN cycles after the write release is seen. `data_oe` stays 0 until a read is asserted.
- R7: A read falling edge seen at least MIN cycles (MIN = ceil(MIN_LOW_NS × CLK_MHZ / 1000), 150 by default) after the write release completes the conversion on the next edge, with `int_n`=0 and the result on `data_out`. An earlier read edge is ignored, and `busy` stays 1.
- R8: With `cs_n` and `rd_n` held at 0 in write-then-read mode, a write pulse alone converts. The result appears on `data_out` and `int_n` falls SPAN cycles after the release is seen.
- R9: After completion, deasserting either read or chip select sets `int_n` back to 1 and releases the bus (`data_oe`=0, `data_out`=0).
- R10: A write held low for fewer than MIN cycles sets `wr_short_err`=1. The upper nibble is still captured. The flag clears when the next conversion starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| mode | input | 1 | Static strap: 0 read-triggered, 1 write-then-read |
| up_res | input | 4 | Upper comparator stage code |
| lo_res | input | 4 | Lower comparator stage code |
| up_compare | output | 1 | Upper stage phase: 1 compare, 0 zero |
| lo_compare | output | 1 | Lower stage phase: 1 compare, 0 zero |
| up_latch | output | 1 | One-cycle pulse after the upper nibble is captured |
| lo_latch | output | 1 | One-cycle pulse after the lower nibble is captured |
| data_oe | output | 1 | Data bus drive enable |
| data_out | output | 8 | Result, zero while the bus is released |
| int_n | output | 1 | Completion interrupt, active low |
| busy | output | 1 | High while a conversion is in progress |
| wr_short_err | output | 1 | Write low time was below the minimum |

## Verification
The assertions assume the strap stays still while a conversion is in progress, since the phase and error properties depend on the mode. The stimulus changes `mode` only after the block has returned to idle. They also assume the comparator codes are steady around each capture. The bench holds `up_res` and `lo_res` fixed for the whole of each conversion, and it changes strobes only on falling clock edges, so the reference model and the design see identical synchronized edges.

// File: rtl/hfc_pkg.sv
package hfc_pkg;

    localparam int NIB_W  = 4;
    localparam int DATA_W = 2 * NIB_W;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RD_UP = 3'd1,
        ST_RD_LO = 3'd2,
        ST_WR_UP = 3'd3,
        ST_WR_LO = 3'd4,
        ST_DONE  = 3'd5
    } seq_st_e;

    typedef struct packed {
        seq_st_e          st;
        logic             up_cmp;
        logic             lo_cmp;
        logic             up_le;
        logic             lo_le;
        logic             oe;
        logic             int_n;
        logic             busy;
        logic             err;
        logic [NIB_W-1:0] up_nib;
        logic [NIB_W-1:0] lo_nib;
    } seq_regs_t;

    // Round a nanosecond interval up to whole clock cycles.
    function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                                 input int unsigned mhz);
        return (ns * mhz + 999) / 1000;
    endfunction

endpackage

// File: rtl/hfc_sync.sv
module hfc_sync #(
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dsync,
    output logic [W-1:0] dprev
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q, sync_q, prev_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[i];
                sync_q <= RST_VAL[i];
                prev_q <= RST_VAL[i];
            end else begin
                meta_q <= din[i];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end

        assign dsync[i] = sync_q;
        assign dprev[i] = prev_q;
    end

endmodule

// File: rtl/hfc_interval.sv
module hfc_interval #(
    parameter int unsigned MIN_CYC  = 150,
    parameter int unsigned SPAN_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic min_met,
    output logic span_done
);

    localparam int CNT_W = (SPAN_CYC > 2) ? $clog2(SPAN_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST     = CNT_W'(SPAN_CYC - 1);
    localparam logic [CNT_W-1:0] MIN_LAST = CNT_W'(MIN_CYC - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clr)
            cnt_d = '0;
        else if (cnt_q != LAST)
            cnt_d = cnt_q + 1'b1;
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign min_met   = (cnt_q >= MIN_LAST);
    assign span_done = (cnt_q == LAST);

endmodule

// File: rtl/hfc_sequencer.sv
module hfc_sequencer
    import hfc_pkg::*;
#(
    parameter int unsigned CLK_MHZ    = 250,
    parameter int unsigned PHASE_NS   = 800,
    parameter int unsigned MIN_LOW_NS = 600
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              mode,
    input  logic [NIB_W-1:0]  up_res,
    input  logic [NIB_W-1:0]  lo_res,
    output logic              up_compare,
    output logic              lo_compare,
    output logic              up_latch,
    output logic              lo_latch,
    output logic              data_oe,
    output logic [DATA_W-1:0] data_out,
    output logic              int_n,
    output logic              busy,
    output logic              wr_short_err
);

    localparam int unsigned SPAN_CYC = ns_to_cycles(PHASE_NS, CLK_MHZ);
    localparam int unsigned MIN_CYC  = ns_to_cycles(MIN_LOW_NS, CLK_MHZ);
    localparam int          N_STRB   = 3;
    localparam int          I_CS     = 2;
    localparam int          I_WR     = 1;
    localparam int          I_RD     = 0;

    // strobe synchronization and edge detection
    logic [N_STRB-1:0] strb_now, strb_prev;

    hfc_sync #(.W(N_STRB), .RST_VAL('1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({cs_n, wr_n, rd_n}),
        .dsync (strb_now),
        .dprev (strb_prev)
    );

    logic wr_act, wr_act_p, rd_act, rd_act_p;
    logic wr_fall, wr_rise, rd_fall, rd_rel;

    assign wr_act   = ~strb_now[I_CS]  & ~strb_now[I_WR];
    assign rd_act   = ~strb_now[I_CS]  & ~strb_now[I_RD];
    assign wr_act_p = ~strb_prev[I_CS] & ~strb_prev[I_WR];
    assign rd_act_p = ~strb_prev[I_CS] & ~strb_prev[I_RD];
    assign wr_fall  = wr_act & ~wr_act_p;
    assign wr_rise  = ~wr_act & wr_act_p;
    assign rd_fall  = rd_act & ~rd_act_p;
    assign rd_rel   = ~rd_act & rd_act_p;

    // phase interval timer
    seq_regs_t d, q;
    logic      tmr_clr, min_met, span_done;

    hfc_interval #(.MIN_CYC(MIN_CYC), .SPAN_CYC(SPAN_CYC)) u_interval (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (tmr_clr),
        .min_met   (min_met),
        .span_done (span_done)
    );

    always_comb begin
        d       = q;
        d.up_le = 1'b0;
        d.lo_le = 1'b0;

        unique case (q.st)
            ST_IDLE: begin
                if (!mode && rd_fall) begin
                    d.st  = ST_RD_UP;
                    d.err = 1'b0;
                end else if (mode && wr_fall) begin
                    d.st  = ST_WR_UP;
                    d.err = 1'b0;
                end
            end
            ST_RD_UP: begin
                if (!rd_act) begin
                    d.st = ST_IDLE;
                end else if (span_done) begin
                    d.st     = ST_RD_LO;
                    d.up_nib = up_res;
                    d.up_le  = 1'b1;
                end
            end
            ST_RD_LO: begin
                if (!rd_act) begin
                    d.st = ST_IDLE;
                end else if (span_done) begin
                    d.st     = ST_DONE;
                    d.lo_nib = lo_res;
                    d.lo_le  = 1'b1;
                end
            end
            ST_WR_UP: begin
                if (wr_rise) begin
                    d.st     = ST_WR_LO;
                    d.up_nib = up_res;
                    d.up_le  = 1'b1;
                    d.err    = ~min_met;
                end
            end
            ST_WR_LO: begin
                if (span_done || (rd_fall && min_met)) begin
                    d.st     = ST_DONE;
                    d.lo_nib = lo_res;
                    d.lo_le  = 1'b1;
                end
            end
            ST_DONE: begin
                if (rd_rel) begin
                    d.st = ST_IDLE;
                end else if (mode && wr_fall) begin
                    d.st  = ST_WR_UP;
                    d.err = 1'b0;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        d.up_cmp = (d.st == ST_RD_UP) || (d.st == ST_WR_UP);
        d.lo_cmp = (d.st == ST_RD_LO) || (d.st == ST_WR_LO);
        d.busy   = d.up_cmp || d.lo_cmp;
        d.int_n  = (d.st != ST_DONE);
        d.oe     = (d.st == ST_DONE) && rd_act;
        tmr_clr  = (d.st != q.st);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, up_cmp: 1'b0, lo_cmp: 1'b0, up_le: 1'b0,
                   lo_le: 1'b0, oe: 1'b0, int_n: 1'b1, busy: 1'b0,
                   err: 1'b0, up_nib: '0, lo_nib: '0};
        end else begin
            q <= d;
        end
    end

    assign up_compare   = q.up_cmp;
    assign lo_compare   = q.lo_cmp;
    assign up_latch     = q.up_le;
    assign lo_latch     = q.lo_le;
    assign data_oe      = q.oe;
    assign data_out     = q.oe ? {q.up_nib, q.lo_nib} : '0;
    assign int_n        = q.int_n;
    assign busy         = q.busy;
    assign wr_short_err = q.err;

endmodule

// File: rtl/hfc_sequencer_chk.sv
module hfc_sequencer_chk
    import hfc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              mode,
    input logic              up_compare,
    input logic              lo_compare,
    input logic              up_latch,
    input logic              lo_latch,
    input logic              data_oe,
    input logic [DATA_W-1:0] data_out,
    input logic              int_n,
    input logic              busy
);

    AST_ONE_STAGE_COMPARES: assert property (@(posedge clk) disable iff (!rst_n)
        !(up_compare && lo_compare)); // R2

    AST_UP_LATCH_AFTER_CMP: assert property (@(posedge clk) disable iff (!rst_n)
        up_latch |-> ($past(up_compare) && lo_compare)); // R5

    AST_LO_LATCH_AFTER_CMP: assert property (@(posedge clk) disable iff (!rst_n)
        lo_latch |-> ($past(lo_compare) && !int_n)); // R3

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !int_n |-> (!busy && !up_compare && !lo_compare)); // R6

    AST_BUS_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> !int_n); // R9

    AST_BUS_RELEASED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !data_oe |-> (data_out == '0)); // R9

    AST_STRAP_STILL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mode)); // R1

endmodule

bind hfc_sequencer hfc_sequencer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .up_compare (up_compare),
    .lo_compare (lo_compare),
    .up_latch   (up_latch),
    .lo_latch   (lo_latch),
    .data_oe    (data_oe),
    .data_out   (data_out),
    .int_n      (int_n),
    .busy       (busy)
);

// File: tb/tb_hfc_sequencer.sv
module tb_hfc_sequencer;

    localparam int CLK_MHZ = 250;
    localparam int SPAN    = (800 * CLK_MHZ + 999) / 1000;
    localparam int MINC    = (600 * CLK_MHZ + 999) / 1000;

    localparam int S_IDLE = 0, S_RUP = 1, S_RLO = 2, S_WUP = 3, S_WLO = 4, S_DONE = 5;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n, cs_n, wr_n, rd_n, mode;
    logic [3:0] up_res, lo_res;
    logic       up_compare, lo_compare, up_latch, lo_latch, data_oe, int_n, busy, wr_short_err;
    logic [7:0] data_out;

    hfc_sequencer dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .mode(mode), .up_res(up_res), .lo_res(lo_res),
        .up_compare(up_compare), .lo_compare(lo_compare),
        .up_latch(up_latch), .lo_latch(lo_latch), .data_oe(data_oe),
        .data_out(data_out), .int_n(int_n), .busy(busy),
        .wr_short_err(wr_short_err)
    );

    int n_chk  = 0;
    int n_fail = 0;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // ---------------- behavioural reference model ----------------
    bit [2:0] h1, h2, h3;         // {cs_n, wr_n, rd_n} delayed by 1, 2, 3 edges
    int       m_st, m_el;         // phase and cycles spent in it
    bit       m_upc, m_loc, m_upl, m_lol, m_oe, m_int_n, m_busy, m_err;
    bit [3:0] m_up, m_lo;
    bit       c_wr, c_rd, p_wr, p_rd;
    int       nx;

    always @(posedge clk) begin
        if (!rst_n) begin
            h1 = 3'b111; h2 = 3'b111; h3 = 3'b111;
            m_st = S_IDLE; m_el = 0;
            m_upc = 0; m_loc = 0; m_upl = 0; m_lol = 0; m_oe = 0;
            m_int_n = 1; m_busy = 0; m_err = 0; m_up = 0; m_lo = 0;
        end else begin
            c_wr = !h2[2] && !h2[1];
            c_rd = !h2[2] && !h2[0];
            p_wr = !h3[2] && !h3[1];
            p_rd = !h3[2] && !h3[0];
            nx = m_st; m_upl = 0; m_lol = 0;
            if (m_st == S_IDLE) begin
                if (!mode && c_rd && !p_rd) begin nx = S_RUP; m_err = 0; end
                else if (mode && c_wr && !p_wr) begin nx = S_WUP; m_err = 0; end
            end else if (m_st == S_RUP || m_st == S_RLO) begin
                if (!c_rd) nx = S_IDLE;
                else if (m_el + 1 >= SPAN) begin
                    if (m_st == S_RUP) begin nx = S_RLO; m_up = up_res; m_upl = 1; end
                    else begin nx = S_DONE; m_lo = lo_res; m_lol = 1; end
                end
            end else if (m_st == S_WUP) begin
                if (!c_wr && p_wr) begin
                    nx = S_WLO; m_up = up_res; m_upl = 1; m_err = (m_el + 1 < MINC);
                end
            end else if (m_st == S_WLO) begin
                if (m_el + 1 >= SPAN || (c_rd && !p_rd && m_el + 1 >= MINC)) begin
                    nx = S_DONE; m_lo = lo_res; m_lol = 1;
                end
            end else begin
                if (!c_rd && p_rd) nx = S_IDLE;
                else if (mode && c_wr && !p_wr) begin nx = S_WUP; m_err = 0; end
            end
            if (nx != m_st) m_el = 0;
            else if (m_el + 1 < SPAN) m_el = m_el + 1;
            m_st    = nx;
            m_upc   = (nx == S_RUP) || (nx == S_WUP);
            m_loc   = (nx == S_RLO) || (nx == S_WLO);
            m_busy  = m_upc || m_loc;
            m_int_n = (nx != S_DONE);
            m_oe    = (nx == S_DONE) && c_rd;
            h3 = h2; h2 = h1; h1 = {cs_n, wr_n, rd_n};
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            check("R2",  "up_compare", up_compare, m_upc);
            check("R5",  "lo_compare", lo_compare, m_loc);
            check("R5",  "up_latch", up_latch, m_upl);
            check("R3",  "lo_latch", lo_latch, m_lol);
            check("R3",  "busy", busy, m_busy);
            check("R6",  "int_n", int_n, m_int_n);
            check("R9",  "data_oe", data_oe, m_oe);
            check("R9",  "data_out", data_out, m_oe ? {m_up, m_lo} : 8'h00);
            check("R10", "wr_short_err", wr_short_err, m_err);
        end
    end

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        finish_run();
    end

    // ---------------- directed stimulus ----------------
    initial begin
        rst_n = 0; cs_n = 1; wr_n = 1; rd_n = 1; mode = 0; up_res = 0; lo_res = 0;
        wait_cyc(5);
        rst_n = 1;
        wait_cyc(4);
        check("R9", "reset int_n", int_n, 1);
        check("R3", "reset busy", busy, 0);
        check("R9", "reset data_out", data_out, 0);

        // R1: write ignored in read-triggered mode
        cs_n = 0; wr_n = 0; wait_cyc(20); wr_n = 1; cs_n = 1; wait_cyc(5);
        check("R1", "busy after write in mode 0", busy, 0);

        // R2 / R3: read-triggered conversion
        up_res = 4'hA; lo_res = 4'h5;
        cs_n = 0; rd_n = 0;
        wait_cyc(100);
        check("R2", "upper compare", up_compare, 1);
        check("R2", "lower zero", lo_compare, 0);
        wait_cyc(200);
        check("R3", "lower compare", lo_compare, 1);
        wait_cyc(120);
        check("R3", "result", data_out, 8'hA5);
        check("R3", "int low", int_n, 0);
        rd_n = 1; wait_cyc(5);
        check("R9", "int released", int_n, 1);
        check("R9", "bus released", data_oe, 0);
        cs_n = 1; wait_cyc(5);

        // R4: aborted read
        cs_n = 0; rd_n = 0; wait_cyc(50); rd_n = 1; wait_cyc(5);
        check("R4", "busy after abort", busy, 0);
        wait_cyc(450);
        check("R4", "no interrupt after abort", int_n, 1);
        cs_n = 1; wait_cyc(5);

        // R1: read ignored in write-then-read mode
        mode = 1; wait_cyc(3);
        cs_n = 0; rd_n = 0; wait_cyc(20); rd_n = 1; cs_n = 1; wait_cyc(5);
        check("R1", "busy after read in mode 1", busy, 0);

        // R5 / R6 / R9: interrupt-driven write then read, released by chip select
        up_res = 4'h3; lo_res = 4'hC;
        cs_n = 0; wr_n = 0; wait_cyc(100);
        check("R5", "upper compare on write", up_compare, 1);
        wait_cyc(60); wr_n = 1; wait_cyc(10);
        check("R5", "lower compare after write", lo_compare, 1);
        check("R5", "upper zero after write", up_compare, 0);
        wait_cyc(250);
        check("R6", "interrupt without read", int_n, 0);
        check("R6", "bus idle before read", data_oe, 0);
        rd_n = 0; wait_cyc(4);
        check("R6", "result on read", data_out, 8'h3C);
        cs_n = 1; wait_cyc(4);
        check("R9", "int released by chip select", int_n, 1);
        check("R9", "bus released by chip select", data_out, 0);
        rd_n = 1; wait_cyc(5);

        // R7: early read
        up_res = 4'h6; lo_res = 4'h9;
        cs_n = 0; wr_n = 0; wait_cyc(160); wr_n = 1;
        wait_cyc(50); rd_n = 0; wait_cyc(5); rd_n = 1; wait_cyc(3);
        check("R7", "too-early read ignored", busy, 1);
        wait_cyc(107); rd_n = 0; wait_cyc(4);
        check("R7", "early read completes", int_n, 0);
        check("R7", "early read data", data_out, 8'h69);
        rd_n = 1; cs_n = 1; wait_cyc(5);

        // R8: stand-alone
        up_res = 4'h2; lo_res = 4'h7;
        cs_n = 0; rd_n = 0; wait_cyc(5);
        wr_n = 0; wait_cyc(160); wr_n = 1;
        wait_cyc(100);
        check("R8", "still converting", busy, 1);
        wait_cyc(110);
        check("R8", "stand-alone interrupt", int_n, 0);
        check("R8", "stand-alone data", data_out, 8'h27);
        cs_n = 1; rd_n = 1; wait_cyc(5);
        check("R9", "released after stand-alone", int_n, 1);

        // R10: short write
        up_res = 4'hB; lo_res = 4'h1;
        cs_n = 0; wr_n = 0; wait_cyc(20); wr_n = 1; wait_cyc(5);
        check("R10", "short write flagged", wr_short_err, 1);
        wait_cyc(210); rd_n = 0; wait_cyc(4);
        check("R10", "upper still captured", data_out, 8'hB1);
        rd_n = 1; wait_cyc(5);
        wr_n = 0; wait_cyc(160); wr_n = 1; wait_cyc(5);
        check("R10", "flag cleared on next write", wr_short_err, 0);
        wait_cyc(220);
        cs_n = 1; wait_cyc(10);

        finish_run();
    end

endmodule